// File: doc/BRIEF.md
# Control Endpoint Register Block with Firmware Write Lock

This block is the firmware-facing register file of a low-speed USB function. It keeps the device address (seven address bits plus an enable flag) and the status/mode register of the default control endpoint. It also decides who owns the status/mode register whenever the firmware and the serial interface engine (SIE) both want to change it. The firmware reaches both registers through a small synchronous read/write bus whose read data is registered. The SIE reports transaction events through single-cycle strobes. It also reports the start of a SETUP data packet and the start of the handshake returned to it.

Once the SIE has posted an event, the status/mode register refuses firmware writes until the firmware has read it. This way firmware cannot erase an event it has not yet seen. An accepted firmware write always wipes the four event flags, whatever data it carries, and loads the four mode bits. The SETUP flag is pinned high for the whole of a SETUP transaction's data stage. The block also compares each token address from the SIE against the stored address and raises a match flag.

Top module: `usb_ep0_regs`

## Requirements
- R1: The address register sits at bus offset 0x00: bits [6:0] hold the device address and bit 7 the enable flag. A firmware write loads all eight bits. After a hardware reset it reads 0x00.
- R2: A USB bus reset pulse clears the address register, the status/mode register, the write lock and the SETUP window. The change is visible after the next clock edge, and a following firmware write to offset 0x01 is accepted.
- R3: `addr_match` is combinational. While enabled it is 1 exactly when `tok_addr` equals the stored address. While disabled it is 1 exactly when `tok_addr` is 0.
- R4: The status/mode register sits at offset 0x01. Bit 7 is SETUP, bit 6 is IN, bit 5 is OUT, bit 4 is ACK, and bits [3:0] are the mode. The IN, OUT and ACK strobes set their bits. The mode-update strobe loads bits [3:0] from `sie_mode`. Other bits keep their value.
- R5: Any IN, OUT, ACK or mode-update strobe sets the write lock. While the lock is set, firmware writes to offset 0x01 leave the register unchanged.
- R6: A firmware read of offset 0x01 releases the lock on the clock edge that completes the read, unless an SIE strobe arrives in that same cycle.
- R7: An accepted firmware write to offset 0x01 clears bits [7:4] whatever the data, and loads bits [3:0] from the written data. Bit 7 is the exception while the SETUP window is open.
- R8: `setup_data_start` sets bit 7 and opens the SETUP window, and `setup_ack_start` closes it. While the window is open, bit 7 stays 1 through accepted writes. Closing the window does not clear bit 7.
- R9: When a firmware write to offset 0x01 and an SIE strobe occur in the same cycle, the write is dropped, the SIE update is applied, and the lock is set.
- R10: Read data appears on `cpu_rdata` one cycle after `cpu_rd`. Offsets other than 0x00 and 0x01 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_reset | input | 1 | USB bus reset pulse from the SIE |
| cpu_addr | input | 5 | Firmware register offset |
| cpu_wr | input | 1 | Firmware write strobe |
| cpu_rd | input | 1 | Firmware read strobe |
| cpu_wdata | input | 8 | Firmware write data |
| cpu_rdata | output | 8 | Registered read data |
| sie_in | input | 1 | IN transaction event strobe |
| sie_out | input | 1 | OUT transaction event strobe |
| sie_ack | input | 1 | Acknowledged transaction event strobe |
| sie_mode_upd | input | 1 | SIE loads the endpoint mode |
| sie_mode | input | 4 | Mode value loaded by the SIE |
| setup_data_start | input | 1 | Start of SETUP data packet |
| setup_ack_start | input | 1 | Start of returned handshake for SETUP |
| tok_addr | input | 7 | Address field of the incoming token |
| dev_addr | output | 7 | Stored device address |
| addr_en | output | 1 | Address enable flag |
| ep0_mode | output | 8 | Status/mode register contents |
| addr_match | output | 1 | Token addressed to this device |

## Verification
A lock flag stuck set shows up one cycle after a read of offset 0x01: the next write does not change `ep0_mode`. A lock flag stuck clear shows up as a firmware write that erases an SIE event still unread. A SETUP window that never opens, or never closes, shows up on bit 7 of `ep0_mode` right after the first accepted write inside the window or after it. A wrong address state shows up at once on `addr_match`, and on `cpu_rdata` one cycle after a read.

// File: rtl/usbep_pkg.sv
package usbep_pkg;

    localparam int DATA_W   = 8;
    localparam int DADDR_W  = 7;
    localparam int MODE_W   = 4;

    // Status/mode register layout; bit order is decoded by firmware
    typedef struct packed {
        logic              setup;
        logic              in_evt;
        logic              out_evt;
        logic              ack_evt;
        logic [MODE_W-1:0] mode;
    } ep0_reg_t;

    typedef struct packed {
        logic               en;
        logic [DADDR_W-1:0] addr;
    } devaddr_reg_t;

    typedef struct packed {
        logic              in_evt;
        logic              out_evt;
        logic              ack_evt;
        logic              mode_upd;
        logic [MODE_W-1:0] mode;
    } sie_evt_t;

    localparam ep0_reg_t     EP0_RST  = '0;
    localparam devaddr_reg_t DADDR_RST = '0;

    function automatic logic sie_any(input sie_evt_t e);
        return e.in_evt | e.out_evt | e.ack_evt | e.mode_upd;
    endfunction

    function automatic ep0_reg_t apply_sie(input ep0_reg_t cur, input sie_evt_t e);
        ep0_reg_t r;
        r = cur;
        if (e.in_evt)   r.in_evt  = 1'b1;
        if (e.out_evt)  r.out_evt = 1'b1;
        if (e.ack_evt)  r.ack_evt = 1'b1;
        if (e.mode_upd) r.mode    = e.mode;
        return r;
    endfunction

endpackage

// File: rtl/usbep_addr_reg.sv
module usbep_addr_reg
    import usbep_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_reset,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DADDR_W-1:0] tok_addr,
    output devaddr_reg_t       q,
    output logic               match
);

    devaddr_reg_t q_r;

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            q_r <= DADDR_RST;
        end else if (wr_en) begin
            q_r <= devaddr_reg_t'(wdata);
        end
    end

    // Disabled device answers only the default address
    always_comb begin
        if (q_r.en) match = (tok_addr == q_r.addr);
        else        match = (tok_addr == '0);
    end

    assign q = q_r;

endmodule

// File: rtl/usbep_ep0_ctl.sv
module usbep_ep0_ctl
    import usbep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  sie_evt_t          sie,
    input  logic              setup_open,
    input  logic              setup_close,
    output ep0_reg_t          q,
    output logic              locked,
    output logic              setup_win
);

    ep0_reg_t q_r, q_nx;
    logic     lock_r, lock_nx;
    logic     win_r, win_nx;
    logic     sie_hit;
    logic     wr_ok;

    assign sie_hit = sie_any(sie);
    // SIE has priority over a firmware write in the same cycle
    assign wr_ok   = wr_en && !lock_r && !sie_hit;

    always_comb begin
        q_nx = q_r;
        if (wr_ok) begin
            q_nx        = EP0_RST;
            q_nx.mode   = wdata[MODE_W-1:0];
        end
        q_nx = apply_sie(q_nx, sie);
        if (setup_open || win_r) q_nx.setup = 1'b1;
    end

    always_comb begin
        if (sie_hit)    lock_nx = 1'b1;
        else if (rd_en) lock_nx = 1'b0;
        else            lock_nx = lock_r;
    end

    always_comb begin
        if (setup_open)       win_nx = 1'b1;
        else if (setup_close) win_nx = 1'b0;
        else                  win_nx = win_r;
    end

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            q_r    <= EP0_RST;
            lock_r <= 1'b0;
            win_r  <= 1'b0;
        end else begin
            q_r    <= q_nx;
            lock_r <= lock_nx;
            win_r  <= win_nx;
        end
    end

    assign q         = q_r;
    assign locked    = lock_r;
    assign setup_win = win_r;

endmodule

// File: rtl/usbep_rd_mux.sv
module usbep_rd_mux
    import usbep_pkg::*;
#(
    parameter int                AW       = 5,
    parameter logic [AW-1:0]     OFS_ADDR = '0,
    parameter logic [AW-1:0]     OFS_EP0  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [AW-1:0]     addr,
    input  devaddr_reg_t      daddr,
    input  ep0_reg_t          ep0,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] sel;

    always_comb begin
        unique case (addr)
            OFS_ADDR: sel = DATA_W'(daddr);
            OFS_EP0:  sel = DATA_W'(ep0);
            default:  sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= sel;
    end

endmodule

// File: rtl/usb_ep0_regs.sv
module usb_ep0_regs
    import usbep_pkg::*;
#(
    parameter int            AW       = 5,
    parameter logic [AW-1:0] OFS_ADDR = 5'h00,
    parameter logic [AW-1:0] OFS_EP0  = 5'h01
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_reset,
    input  logic [AW-1:0]      cpu_addr,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               sie_in,
    input  logic               sie_out,
    input  logic               sie_ack,
    input  logic               sie_mode_upd,
    input  logic [MODE_W-1:0]  sie_mode,
    input  logic               setup_data_start,
    input  logic               setup_ack_start,
    input  logic [DADDR_W-1:0] tok_addr,
    output logic [DADDR_W-1:0] dev_addr,
    output logic               addr_en,
    output logic [DATA_W-1:0]  ep0_mode,
    output logic               addr_match
);

    devaddr_reg_t daddr_q;
    ep0_reg_t     ep0_q;
    sie_evt_t     sie_ev;
    logic         sel_addr, sel_ep0;
    logic         ep_locked, ep_setup_win, sie_hit;

    assign sel_addr = (cpu_addr == OFS_ADDR);
    assign sel_ep0  = (cpu_addr == OFS_EP0);

    assign sie_ev = '{in_evt: sie_in, out_evt: sie_out, ack_evt: sie_ack,
                      mode_upd: sie_mode_upd, mode: sie_mode};
    assign sie_hit = sie_any(sie_ev);

    usbep_addr_reg u_addr (
        .clk      (clk),
        .rst      (rst),
        .bus_reset(bus_reset),
        .wr_en    (cpu_wr && sel_addr),
        .wdata    (cpu_wdata),
        .tok_addr (tok_addr),
        .q        (daddr_q),
        .match    (addr_match)
    );

    usbep_ep0_ctl u_ep0 (
        .clk        (clk),
        .rst        (rst),
        .bus_reset  (bus_reset),
        .wr_en      (cpu_wr && sel_ep0),
        .rd_en      (cpu_rd && sel_ep0),
        .wdata      (cpu_wdata),
        .sie        (sie_ev),
        .setup_open (setup_data_start),
        .setup_close(setup_ack_start),
        .q          (ep0_q),
        .locked     (ep_locked),
        .setup_win  (ep_setup_win)
    );

    usbep_rd_mux #(.AW(AW), .OFS_ADDR(OFS_ADDR), .OFS_EP0(OFS_EP0)) u_rd (
        .clk  (clk),
        .rst  (rst),
        .rd   (cpu_rd),
        .addr (cpu_addr),
        .daddr(daddr_q),
        .ep0  (ep0_q),
        .rdata(cpu_rdata)
    );

    assign dev_addr = daddr_q.addr;
    assign addr_en  = daddr_q.en;
    assign ep0_mode = ep0_q;

endmodule

// File: rtl/usbep_chk.sv
module usbep_chk
    import usbep_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_reset,
    input logic               cpu_wr,
    input logic               sel_ep0,
    input logic [DATA_W-1:0]  cpu_wdata,
    input logic               sie_hit,
    input logic               setup_data_start,
    input logic               locked,
    input logic               setup_win,
    input logic [DATA_W-1:0]  ep0_mode,
    input logic [DADDR_W-1:0] dev_addr,
    input logic               addr_en,
    input logic [DADDR_W-1:0] tok_addr,
    input logic               addr_match
);

    assert_bus_reset_clears_R2: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (dev_addr == '0 && !addr_en && ep0_mode == '0 && !locked));

    assert_match_default_R3: assert property (@(posedge clk) disable iff (rst)
        (!addr_en && addr_match) |-> (tok_addr == '0));

    assert_event_locks_R5: assert property (@(posedge clk) disable iff (rst || bus_reset)
        sie_hit |=> locked);

    assert_locked_write_dropped_R5: assert property (@(posedge clk) disable iff (rst || bus_reset)
        (locked && cpu_wr && sel_ep0 && !sie_hit && !setup_data_start) |=> $stable(ep0_mode));

    assert_write_clears_flags_R7: assert property (@(posedge clk) disable iff (rst || bus_reset)
        (!locked && cpu_wr && sel_ep0 && !sie_hit && !setup_data_start && !setup_win)
        |=> (ep0_mode == {4'h0, $past(cpu_wdata[3:0])}));

    assert_setup_pinned_R8: assert property (@(posedge clk) disable iff (rst || bus_reset)
        setup_win |-> ep0_mode[7]);

endmodule

bind usb_ep0_regs usbep_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .bus_reset       (bus_reset),
    .cpu_wr          (cpu_wr),
    .sel_ep0         (sel_ep0),
    .cpu_wdata       (cpu_wdata),
    .sie_hit         (sie_hit),
    .setup_data_start(setup_data_start),
    .locked          (ep_locked),
    .setup_win       (ep_setup_win),
    .ep0_mode        (ep0_mode),
    .dev_addr        (dev_addr),
    .addr_en         (addr_en),
    .tok_addr        (tok_addr),
    .addr_match      (addr_match)
);

// File: tb/sim_usb_ep0_regs.sv
module sim_usb_ep0_regs;

    logic       clk = 0, rst = 1, bus_reset = 0;
    logic [4:0] cpu_addr = 0;
    logic       cpu_wr = 0, cpu_rd = 0;
    logic [7:0] cpu_wdata = 0, cpu_rdata;
    logic       sie_in = 0, sie_out = 0, sie_ack = 0, sie_mode_upd = 0;
    logic [3:0] sie_mode = 0;
    logic       setup_data_start = 0, setup_ack_start = 0;
    logic [6:0] tok_addr = 0, dev_addr;
    logic       addr_en, addr_match;
    logic [7:0] ep0_mode;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_pend = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    usb_ep0_regs u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare registered read data one cycle after the strobe
    always @(posedge clk) rd_pend <= cpu_rd;
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, cpu_rdata, e);
        end
    end

    task automatic idle();
        cpu_wr = 0; cpu_rd = 0; sie_in = 0; sie_out = 0; sie_ack = 0;
        sie_mode_upd = 0; setup_data_start = 0; setup_ack_start = 0; bus_reset = 0;
    endtask

    task automatic cpu_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
        @(negedge clk); idle();
    endtask

    task automatic cpu_read(input logic [4:0] a, input logic [7:0] e, input string t);
        @(negedge clk); cpu_addr = a; cpu_rd = 1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset addr", {addr_en, dev_addr}, 0);
        check("R1 reset ep0", ep0_mode, 0);
        check("R10 reset rdata", cpu_rdata, 0);

        tok_addr = 0; #1 check("R3 disabled matches 0", addr_match, 1);
        tok_addr = 5; #1 check("R3 disabled no match 5", addr_match, 0);

        cpu_write(5'h00, 8'h85);
        check("R1 addr loaded", dev_addr, 5);
        check("R1 enable set", addr_en, 1);
        #1 check("R3 enabled matches 5", addr_match, 1);
        tok_addr = 0; #1 check("R3 enabled no match 0", addr_match, 0);
        cpu_read(5'h00, 8'h85, "R10 read addr");
        cpu_read(5'h03, 8'h00, "R10 unused offset");

        cpu_write(5'h01, 8'h3A);
        check("R7 write clears flags", ep0_mode, 8'h0A);

        @(negedge clk); sie_in = 1; @(negedge clk); idle();
        check("R4 IN sets bit6", ep0_mode, 8'h4A);
        cpu_write(5'h01, 8'h01);
        check("R5 locked write dropped", ep0_mode, 8'h4A);

        cpu_read(5'h01, 8'h4A, "R6 read ep0");
        cpu_write(5'h01, 8'h03);
        check("R6 unlocked after read", ep0_mode, 8'h03);

        @(negedge clk); sie_mode_upd = 1; sie_mode = 4'h9; sie_out = 1; sie_ack = 1;
        @(negedge clk); idle();
        check("R4 OUT ACK mode update", ep0_mode, 8'h39);

        cpu_read(5'h01, 8'h39, "R6 read before race");
        @(negedge clk); cpu_addr = 5'h01; cpu_wdata = 8'h05; cpu_wr = 1; sie_in = 1;
        @(negedge clk); idle();
        check("R9 SIE wins same cycle", ep0_mode, 8'h79);
        cpu_write(5'h01, 8'h00);
        check("R9 lock set by race", ep0_mode, 8'h79);

        cpu_read(5'h01, 8'h79, "R6 read unlock");
        @(negedge clk); setup_data_start = 1; @(negedge clk); idle();
        check("R8 setup sets bit7", ep0_mode, 8'hF9);
        cpu_write(5'h01, 8'h02);
        check("R8 bit7 held in window", ep0_mode, 8'h82);
        @(negedge clk); setup_ack_start = 1; @(negedge clk); idle();
        check("R8 bit7 kept after close", ep0_mode, 8'h82);
        cpu_write(5'h01, 8'h02);
        check("R7 bit7 cleared after window", ep0_mode, 8'h02);

        @(negedge clk); sie_out = 1; @(negedge clk); idle();
        @(negedge clk); bus_reset = 1; @(negedge clk); idle();
        check("R2 bus reset addr", {addr_en, dev_addr}, 0);
        check("R2 bus reset ep0", ep0_mode, 0);
        cpu_write(5'h01, 8'h04);
        check("R2 lock cleared", ep0_mode, 8'h04);

        repeat (2) @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule